// File: doc/BRIEF.md
# Counter-Seeded Reseeding Pattern Generator

This block is a pseudo-random stimulus source for built-in self-test. A maximal-length linear feedback shift register of `WIDTH` bits (8 by default) produces one new pattern on every clock while a test run is active. A local counter supplies the seeds. Seeds are loaded one after another, starting at 1 and never taking the value zero. Each seed is kept for exactly one full register period of 2^WIDTH − 1 clocks before the next one replaces it.

A single-cycle `start` pulse begins a run. The block then steps through every nonzero seed. After the window of the last seed it raises `done` and stops; its outputs stay frozen until `start` arrives again. The circuit under test consumes `pattern` whenever `pattern_valid` is high. `pattern_valid` is never high while the register holds the all-zero lock state, so a stuck register can never be presented as a test vector.

Top module: `tpg_reseed`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `seed` reads 1 and `pattern`, `pattern_valid` and `done` read 0.
- R2: A `start` pulse given while idle makes `pattern` equal the current `seed` one clock later, with `pattern_valid` high and `done` low.
- R3: Each seed stays on the `seed` output for exactly 2^WIDTH − 1 consecutive valid cycles. When the window ends, `seed` increments by one, and in that same cycle `pattern` equals the new seed.
- R4: Within a seed window, each pattern is the previous one shifted one place toward the MSB. The new LSB is the XOR of previous bits 7, 5, 4 and 3, which is the tap mask 8'hB8 for the polynomial x^8+x^6+x^5+x^4+1. Every window therefore yields 255 distinct nonzero patterns.
- R5: `pattern_valid` is high exactly when a run is active and `pattern` is nonzero. It is never high with an all-zero pattern.
- R6: The seed counter never produces zero. After the window of seed 2^WIDTH − 1, `seed` returns to 1, `done` rises, `pattern_valid` falls and `pattern` holds still while idle.
- R7: A `start` pulse during an active run has no effect on `pattern`, `seed` or the window timing.
- R8: A `start` pulse after `done` clears `done` one clock later and begins a new run from seed 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins a run when idle |
| pattern | output | WIDTH | Current test pattern |
| pattern_valid | output | 1 | Pattern may be applied to the circuit under test |
| seed | output | WIDTH | Seed of the current window |
| done | output | 1 | All seeds have been used; generator idle |

## Verification
A corrupted shift register shows up within one clock as a `pattern` that differs from the model's prediction. If it falls into the lock state, `pattern_valid` drops in that same cycle. A window counter that is off by even one cycle moves the seed change, so the bench sees the error at the first reload, 255 clocks into a run. A seed counter that skips or repeats a value, or fails to stop at the end, is seen at the next reload or at the final `done`.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;
endpackage

// File: rtl/tpg_lfsr_step.sv
module tpg_lfsr_step #(
    parameter int          WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'hB8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             is_zero
);
    logic fb;
    always_comb begin
        fb      = ^(cur & TAPS);
        nxt     = {cur[WIDTH-2:0], fb};
        is_zero = (cur == '0);
    end
endmodule

// File: rtl/tpg_seed_step.sv
module tpg_seed_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] nxt,
    output logic             last
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
    always_comb begin
        last = (cur == '1);
        nxt  = last ? ONE : cur + ONE;
    end
endmodule

// File: rtl/tpg_period_cnt.sv
module tpg_period_cnt #(
    parameter int CW    = 8,
    parameter int LIMIT = 255
) (
    input  logic [CW-1:0] cur,
    output logic [CW-1:0] nxt,
    output logic          term
);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);
    always_comb begin
        term = (cur == LAST);
        nxt  = term ? '0 : cur + CW'(1);
    end
endmodule

// File: rtl/tpg_reseed.sv
module tpg_reseed
    import tpg_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'hB8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [WIDTH-1:0] pattern,
    output logic             pattern_valid,
    output logic [WIDTH-1:0] seed,
    output logic             done
);
    localparam int PERIOD = (1 << WIDTH) - 1;
    localparam int CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    typedef struct packed {
        phase_e           ph;
        logic [WIDTH-1:0] lfsr;
        logic [WIDTH-1:0] seed;
        logic [CW-1:0]    cnt;
        logic             valid;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    logic [WIDTH-1:0] shift_nxt, seed_nxt;
    logic             lfsr_zero_unused, seed_last;
    logic [CW-1:0]    cnt_nxt;
    logic             cnt_term;

    tpg_lfsr_step #(.WIDTH(WIDTH), .TAPS(TAPS)) u_step (
        .cur(st_q.lfsr), .nxt(shift_nxt), .is_zero(lfsr_zero_unused)
    );
    tpg_seed_step #(.WIDTH(WIDTH)) u_seed (
        .cur(st_q.seed), .nxt(seed_nxt), .last(seed_last)
    );
    tpg_period_cnt #(.CW(CW), .LIMIT(PERIOD)) u_cnt (
        .cur(st_q.cnt), .nxt(cnt_nxt), .term(cnt_term)
    );

    always_comb begin
        st_d = st_q;
        if (st_q.ph == PH_IDLE) begin
            if (start) begin
                st_d.ph   = PH_RUN;
                st_d.lfsr = st_q.seed;
                st_d.cnt  = '0;
                st_d.done = 1'b0;
            end
        end else if (cnt_term) begin
            st_d.seed = seed_nxt;
            st_d.cnt  = '0;
            if (seed_last) begin
                st_d.ph   = PH_IDLE;
                st_d.done = 1'b1;
            end else begin
                st_d.lfsr = seed_nxt;
            end
        end else begin
            st_d.lfsr = shift_nxt;
            st_d.cnt  = cnt_nxt;
        end
        st_d.valid = (st_d.ph == PH_RUN) && (st_d.lfsr != '0);
        if (rst) begin
            st_d.ph    = PH_IDLE;
            st_d.lfsr  = '0;
            st_d.seed  = WIDTH'(1);
            st_d.cnt   = '0;
            st_d.valid = 1'b0;
            st_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pattern       = st_q.lfsr;
    assign pattern_valid = st_q.valid;
    assign seed          = st_q.seed;
    assign done          = st_q.done;

    a_r5_no_lock_pattern: assert property (@(posedge clk) disable iff (rst)
        pattern_valid |-> (pattern != '0));

    a_r6_seed_nonzero: assert property (@(posedge clk) disable iff (rst)
        seed != '0);

    a_r6_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !pattern_valid);

    a_r3_reload_seed: assert property (@(posedge clk) disable iff (rst)
        (!$stable(seed) && !done) |-> (pattern == seed) && (seed == $past(seed) + WIDTH'(1)));

    a_r1_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (seed == WIDTH'(1)) && !done && !pattern_valid);
endmodule

// File: tb/tb_tpg_reseed.sv
module tb_tpg_reseed;
    localparam int W = 8;
    localparam int PERIOD = 255;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [W-1:0] pattern, seed;
    logic         pattern_valid, done;

    int total = 0, bad = 0, cycles = 0;

    int m_run, m_seed, m_pat, m_cnt, m_done, m_valid;
    bit seen [256];
    int ndist = 0, hold = 0, prev_seed = 1, prev_done = 0;

    always #5 clk = ~clk;

    tpg_reseed #(.WIDTH(W)) dut (
        .clk(clk), .rst(rst), .start(start), .pattern(pattern),
        .pattern_valid(pattern_valid), .seed(seed), .done(done)
    );

    function automatic int lfsr_next(int p);
        int fb;
        fb = ((p >> 7) ^ (p >> 5) ^ (p >> 4) ^ (p >> 3)) & 1;
        return ((p << 1) & 255) | fb;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic model_update(input bit st, input bit rs);
        if (rs) begin
            m_run = 0; m_seed = 1; m_pat = 0; m_cnt = 0; m_done = 0;
        end else if (!m_run) begin
            if (st) begin m_run = 1; m_pat = m_seed; m_cnt = 0; m_done = 0; end
        end else if (m_cnt == PERIOD - 1) begin
            m_cnt = 0;
            if (m_seed == 255) begin m_seed = 1; m_done = 1; m_run = 0; end
            else begin m_seed = m_seed + 1; m_pat = m_seed; end
        end else begin
            m_pat = lfsr_next(m_pat); m_cnt = m_cnt + 1;
        end
        m_valid = (m_run != 0 && m_pat != 0) ? 1 : 0;
    endtask

    task automatic clear_window();
        for (int i = 0; i < 256; i++) seen[i] = 0;
        ndist = 0; hold = 0;
    endtask

    task automatic compare();
        check(pattern == W'(m_pat), "R4 pattern", pattern, m_pat);
        check(pattern_valid == m_valid[0], "R5 valid", pattern_valid, m_valid);
        check(seed == W'(m_seed), "R3 seed", seed, m_seed);
        check(done == m_done[0], "R6 done", done, m_done);
        if (!rst) begin
            if ((int'(seed) != prev_seed) || (done && !prev_done)) begin
                if (hold > 0) begin
                    check(hold == PERIOD, "R3 window length", hold, PERIOD);
                    check(ndist == PERIOD, "R4 distinct patterns", ndist, PERIOD);
                end
                clear_window();
            end
            if (pattern_valid) begin
                if (!seen[pattern]) begin seen[pattern] = 1; ndist++; end
                hold++;
            end
        end
        prev_seed = int'(seed);
        prev_done = int'(done);
    endtask

    task automatic cyc(input bit st, input bit rs);
        start = st; rst = rs;
        @(posedge clk);
        model_update(st, rs);
        @(negedge clk);
        cycles++;
        compare();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        clear_window();
        @(negedge clk);
        // R1: reset state
        repeat (3) cyc(1'b0, 1'b1);
        check(seed == W'(1) && !done && !pattern_valid && pattern == '0, "R1 reset", seed, 1);
        cyc(1'b0, 1'b0);
        check(seed == W'(1) && !done && !pattern_valid, "R1 after reset", seed, 1);
        repeat (4) cyc(1'b0, 1'b0);
        check(!pattern_valid, "R5 idle invalid", pattern_valid, 0);
        // R2: start loads seed
        cyc(1'b1, 1'b0);
        check(pattern == W'(1) && pattern_valid, "R2 first pattern", pattern, 1);
        repeat (100) cyc(1'b0, 1'b0);
        // R7: start during run ignored
        cyc(1'b1, 1'b0);
        repeat (3) cyc(1'b1, 1'b0);
        check(seed == W'(1) && pattern_valid, "R7 start ignored", seed, 1);
        while (!done && cycles < 190000) cyc(1'b0, 1'b0);
        // R6: end of run
        check(done && seed == W'(1) && !pattern_valid, "R6 final", seed, 1);
        begin
            logic [W-1:0] held;
            held = pattern;
            repeat (4) cyc(1'b0, 1'b0);
            check(pattern == held && done, "R6 frozen", pattern, held);
        end
        // R8: restart
        cyc(1'b1, 1'b0);
        check(!done && seed == W'(1) && pattern == W'(1), "R8 restart", seed, 1);
        repeat (300) cyc(1'b0, 1'b0);
        check(seed == W'(2), "R8 second window", seed, 2);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule